// File: doc/BRIEF.md
# Packed Decimal to Extended-Real Converter

This block takes an 80-bit signed packed decimal integer and turns it into an exact, normalized 80-bit double-extended floating-point value. The output holds a sign bit, a 15-bit biased exponent and a 64-bit significand whose integer bit is explicit. It is meant to sit in a floating-point load path. The result leaves as a push request to a register stack, together with the C1 condition bit that reports a stack overflow on that push.

Internally the eighteen decimal digits are folded into a binary integer one digit per clock, starting from the most significant digit. A leading-zero count then shifts the integer until its top bit is set, and the exponent is derived from the shift amount. Eighteen digits always fit in 64 bits, so the conversion never rounds. A zero magnitude yields a zero exponent and significand and keeps its sign. Both sides of the block use a valid/ready handshake, and only one conversion is in flight at a time.

Top module: `bcd80_to_xreal`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_c1 is 0.
- R2: A source is accepted on a clock edge where in_valid and in_ready are both 1. From that edge until the result is consumed, in_ready is 0, and in_valid and in_bcd have no effect on the pending result.
- R3: out_valid first reads 1 exactly 19 clock edges after the accepting edge: 18 digit steps plus one normalize step.
- R4: Source digit k (k = 0..17) sits in in_bcd[4k+3:4k], so the least significant digit is in bits 3:0. The magnitude is the sum of digit k times 10^k. For a non-zero magnitude, out_value[63:0] is the magnitude shifted left by s, where s is the smallest shift that sets bit 63. out_value[78:64] is 16383 + 63 - s.
- R5: A zero magnitude gives out_value[78:0] = 0 and keeps the source sign, so a negative zero stays negative.
- R6: out_value[79] equals in_bcd[79] of the accepted source.
- R7: in_bcd[78:72] has no effect on the result.
- R8: A nibble from 10 to 15 is weighted by its plain binary value in the same digit sum. The result is deterministic, and the nibble is not flagged.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_value stays unchanged.
- R10: out_c1 equals stack_full while out_valid is 1.
- R11: On the edge where out_valid and out_ready are both 1, the result is consumed. On the next cycle out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source operand offered |
| in_ready | output | 1 | Block idle and able to accept a source |
| in_bcd | input | 80 | Packed decimal source: sign in bit 79, digits in bits 71:0 |
| out_valid | output | 1 | Push request carrying a converted value |
| out_ready | input | 1 | Register stack takes the push |
| out_value | output | 80 | Extended-real result: {sign, exponent[14:0], significand[63:0]} |
| stack_full | input | 1 | Register stack has no free slot for the push |
| out_c1 | output | 1 | Condition bit C1: 1 when the push overflows the stack |

## Verification
A corrupted digit shift register or accumulator does not show up at the ports until the push request appears, 19 cycles after acceptance. It then shows as a wrong significand, or as a normalization shift that is off and moves the exponent. The bench therefore compares every result against a digit-sum model and against hand-computed encodings. A sequencing fault shows sooner: a wrong step count appears as a result that arrives one cycle early or late. A stuck control state appears as in_ready coming back early, or as a result that is dropped or altered while the push is held off.

// File: rtl/bcdx_pkg.sv
`timescale 1ns/1ps
package bcdx_pkg;
    localparam int DIGITS = 18;
    localparam int NIB    = 4;
    localparam int BCD_W  = DIGITS * NIB;
    localparam int SRC_W  = 80;
    localparam int SIGN_B = SRC_W - 1;
    localparam int SIG_W  = 64;
    localparam int EXP_W  = 15;
    localparam int BIAS   = 16383;
    localparam int LZ_W   = $clog2(SIG_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_NORM,
        ST_OUT
    } ctl_state_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } xreal_t;

    // Number of zero bits above the most significant one; SIG_W for zero.
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [SIG_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + LZ_W'(1);
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/bcdx_accum.sv
`timescale 1ns/1ps
module bcdx_accum #(
    parameter int DIGITS = bcdx_pkg::DIGITS,
    parameter int NIB    = bcdx_pkg::NIB,
    parameter int ACC_W  = bcdx_pkg::SIG_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    step,
    input  logic [DIGITS*NIB-1:0]   src,
    output logic [ACC_W-1:0]        acc,
    output logic                    last
);
    localparam int DW    = DIGITS * NIB;
    localparam int CNT_W = $clog2(DIGITS);

    logic [DW-1:0]    digits_q;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NIB-1:0]   head;

    assign head = digits_q[DW-1 -: NIB];

    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            digits_q <= src;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (step) begin
            acc_q    <= acc_q * ACC_W'(10) + ACC_W'(head);
            digits_q <= digits_q << NIB;
            cnt_q    <= cnt_q + CNT_W'(1);
        end
    end

    assign acc  = acc_q;
    assign last = (cnt_q == CNT_W'(DIGITS - 1));
endmodule

// File: rtl/bcdx_norm.sv
`timescale 1ns/1ps
module bcdx_norm #(
    parameter int SIG_W = bcdx_pkg::SIG_W,
    parameter int EXP_W = bcdx_pkg::EXP_W,
    parameter int BIAS  = bcdx_pkg::BIAS
) (
    input  logic [SIG_W-1:0] mag,
    output logic [EXP_W-1:0] exp,
    output logic [SIG_W-1:0] sig
);
    import bcdx_pkg::*;

    logic [LZ_W-1:0] lz;
    logic            is_zero;

    always_comb begin
        lz      = lead_zeros(mag);
        is_zero = (mag == '0);
        if (is_zero) begin
            exp = '0;
            sig = '0;
        end else begin
            exp = EXP_W'(BIAS + SIG_W - 1) - EXP_W'(lz);
            sig = mag << lz;
        end
    end
endmodule

// File: rtl/bcd80_to_xreal.sv
`timescale 1ns/1ps
module bcd80_to_xreal
    import bcdx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SRC_W-1:0] in_bcd,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SRC_W-1:0] out_value,
    input  logic             stack_full,
    output logic             out_c1
);
    ctl_state_e       state_q;
    logic             sign_q;
    xreal_t           res_q;
    logic             accept;
    logic [SIG_W-1:0] mag;
    logic             last;
    logic [EXP_W-1:0] n_exp;
    logic [SIG_W-1:0] n_sig;

    assign accept = in_valid && (state_q == ST_IDLE);

    bcdx_accum #(.DIGITS(DIGITS), .NIB(NIB), .ACC_W(SIG_W)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .step (state_q == ST_ACC),
        .src  (in_bcd[BCD_W-1:0]),
        .acc  (mag),
        .last (last)
    );

    bcdx_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W), .BIAS(BIAS)) u_norm (
        .mag (mag),
        .exp (n_exp),
        .sig (n_sig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sign_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        sign_q  <= in_bcd[SIGN_B];
                        state_q <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (last) state_q <= ST_NORM;
                end
                ST_NORM: begin
                    res_q.sign <= sign_q;
                    res_q.exp  <= n_exp;
                    res_q.sig  <= n_sig;
                    state_q    <= ST_OUT;
                end
                ST_OUT: begin
                    if (out_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_OUT);
    assign out_value = res_q;
    assign out_c1    = out_valid && stack_full;
endmodule

// File: rtl/bcd80_to_xreal_chk.sv
`timescale 1ns/1ps
module bcd80_to_xreal_chk
    import bcdx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [SRC_W-1:0] in_bcd,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SRC_W-1:0] out_value,
    input logic             stack_full,
    input logic             out_c1
);
    localparam int LAT_DONE = DIGITS + 2;
    localparam int LAT_W    = $clog2(LAT_DONE + 1) + 1;

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)                        lat_q <= '0;
        else if (in_valid && in_ready)  lat_q <= LAT_W'(1);
        else if (!in_ready && !out_valid) lat_q <= lat_q + LAT_W'(1);
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid && !out_c1));

    assert_busy_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (lat_q == LAT_W'(LAT_DONE)));

    assert_not_early_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !out_valid) |-> (lat_q <= LAT_W'(LAT_DONE - 1)));

    assert_normalized_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_value[78:64] != '0) |-> out_value[63]);

    assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_value[78:64] == '0) |-> (out_value[63:0] == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value)));

    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind bcd80_to_xreal bcd80_to_xreal_chk u_chk (.*);

// File: tb/bcd80_to_xreal_test.sv
`timescale 1ns/1ps
module bcd80_to_xreal_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [79:0] in_bcd = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [79:0] out_value;
    logic        stack_full = 1'b0;
    logic        out_c1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bcd80_to_xreal uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bcd(in_bcd), .out_valid(out_valid), .out_ready(out_ready),
        .out_value(out_value), .stack_full(stack_full), .out_c1(out_c1)
    );

    localparam logic [79:0] VEC [10] = '{
        80'h00_000000000000000000,
        80'h80_000000000000000000,
        80'h00_000000000000000001,
        80'h80_000000000000000009,
        80'h00_000000000000000010,
        80'h00_999999999999999999,
        80'h80_100000000000000000,
        80'h00_000000000012345678,
        80'h7F_000000000000000042,
        80'h00_00000000000000000F
    };

    function automatic logic [79:0] model(input logic [79:0] b);
        logic [63:0] a  = '0;
        int          sh = 0;
        for (int i = 17; i >= 0; i--) a = a * 64'd10 + 64'(b[i*4 +: 4]);
        if (a == '0) return {b[79], 79'b0};
        while (!a[63]) begin
            a  = a << 1;
            sh = sh + 1;
        end
        return {b[79], 15'(16383 + 63 - sh), a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [79:0] bcd, input logic sf, input logic [79:0] exp_v, input string tag);
        int          n;
        logic [79:0] held;
        @(negedge clk);
        in_valid   = 1'b1;
        in_bcd     = bcd;
        stack_full = sf;
        @(negedge clk);
        in_bcd = ~bcd;            // R2: junk offered while busy
        n = 0;
        while (!out_valid && n < 100) begin
            if (n == 5) chk(!in_ready, {"R2 busy ", tag}, 80'(in_ready), 80'(0));
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        chk(n == 19, {"R3 latency ", tag}, 80'(n), 80'(19));
        chk(out_value == exp_v, {"R4 R5 R6 R7 R8 value ", tag}, out_value, exp_v);
        chk(out_c1 == sf, {"R10 c1 ", tag}, 80'(out_c1), 80'(sf));
        held = out_value;
        @(negedge clk);
        chk(out_valid && out_value == held, {"R9 hold ", tag}, out_value, held);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, {"R11 release ", tag},
            80'({out_valid, in_ready}), 80'(2'b01));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !out_valid && !out_c1, "R1 reset idle",
            80'({in_ready, out_valid, out_c1}), 80'(3'b100));

        // table walk against the digit-sum model
        for (int i = 0; i < 10; i++)
            run_one(VEC[i], 1'(i % 2), model(VEC[i]), $sformatf("vec%0d", i));

        // directed encodings computed by hand
        run_one(80'h00_000000000000000001, 1'b0, 80'h3FFF_8000000000000000, "R4 one");
        run_one(80'h00_000000000000000010, 1'b1, 80'h4002_A000000000000000, "R4 ten");
        run_one(80'h80_000000000000000000, 1'b0, 80'h8000_0000000000000000, "R5 neg zero");
        run_one(80'h00_000000000000000000, 1'b0, 80'h0000_0000000000000000, "R5 pos zero");
        run_one(80'hFF_000000000000000042, 1'b0, 80'hC004_A800000000000000, "R6 R7 ignored bits");
        run_one(80'h00_00000000000000000F, 1'b0, 80'h4002_F000000000000000, "R8 nibble F");

        // reset in the middle of a conversion returns to idle
        @(negedge clk);
        in_valid = 1'b1;
        in_bcd   = 80'h00_000000000000000077;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 reset mid-run",
            80'({in_ready, out_valid}), 80'(2'b10));
        run_one(80'h80_000000000000000123, 1'b1, model(80'h80_000000000000000123), "after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 80'(0), 80'(1));
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule